// File: doc/BRIEF.md
# Serial Receive Holding Register with Interrupt

This block is the register face of a byte-oriented serial peripheral. It does not contain the receiver itself. A receiver elsewhere presents each finished byte on a stream input. The block keeps that byte in a one-byte holding slot and raises a receive-pending flag in a status word. If software has enabled it, the block also sends a one-cycle interrupt pulse.

Software reaches the block through a simple single-cycle register port. Read data is combinational on the same cycle as the request. A read of the data offset returns the held byte and clears the pending flag as a side effect. A write to the same offset emits the byte on a transmit stream output instead. The status word always shows the transmitter as idle and ready, and no interrupt ever comes from the transmit side. When software turns on the receive interrupt while a byte is already waiting, the block raises the request at once.

The receive stream never applies back-pressure: `rx_ready` is held high, so every beat with `rx_valid` high is taken in that cycle. A byte that arrives while the slot is full replaces the older byte. The transmit stream has no ready input, because the downstream shifter is taken to accept one byte per cycle. `tx_valid` is a one-cycle strobe.

Top module: `uart_rx_regs`

## Requirements
- R1: A cycle with `rx_valid` high stores `rx_data` in the holding slot. From the next cycle, status bit 5 (receive pending) reads 1. `rx_ready` is always 1.
- R2: A read at offset 0x04 returns the held byte in bits 7:0, with bits 31:8 zero. From the next cycle, status bit 5 reads 0.
- R3: A write at offset 0x04 produces `tx_valid` = 1 with `tx_data` = wdata[7:0] for exactly the following cycle. It leaves the holding slot and its flag unchanged and never raises `irq`.
- R4: A read at offset 0x00 returns 0xC0 with the pending bit 5 ORed in: bits 7 and 6 are always 1, and every other bit is 0. Writes to offset 0x00 change nothing.
- R5: Bit 5 of the control word at offset 0x0C enables the receive interrupt. While it is set, each arrival gives `irq` = 1 for exactly the cycle after the arrival.
- R6: While the enable bit is clear, an arrival sets the pending flag but `irq` stays 0.
- R7: A control write that changes bit 5 from 0 to 1 while a byte is pending gives `irq` = 1 in the next cycle. The same write with nothing pending raises no request.
- R8: An arrival while a byte is already pending overwrites the slot. The next data read returns the newer byte.
- R9: When an arrival and a data read fall in the same cycle, the read returns the older byte. The flag stays set, and the slot then holds the new byte.
- R10: Offsets 0x08, 0x0C, 0x10 and 0x14 are plain 32-bit read/write storage. Offsets 0x18 and 0x1C read as 0. Address bits 1:0 are ignored.
- R11: After reset, status reads 0xC0, the four storage words read 0, and `irq` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always 1, no back-pressure |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle as the request |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | One-cycle receive interrupt request |

## Verification
Two events can meet in one clock, and the bench provokes both. The first is a byte arrival in the same cycle as a data-register read. In that case the bench expects the old byte on `rd_data`, a pending flag that is still set afterwards, and the new byte on the following read. The second is an arrival in the same cycle as a control write that turns the enable on. There the bench expects exactly one `irq` cycle, and it checks the cycle after that pulse to confirm that no second request follows.

// File: rtl/uart_rx_regs_pkg.sv
package uart_rx_regs_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  // Word index of each register (byte offset / 4)
  typedef enum logic [IDX_W-1:0] {
    IDX_STAT = 3'd0,
    IDX_DATA = 3'd1,
    IDX_BAUD = 3'd2,
    IDX_CTL1 = 3'd3,
    IDX_CTL2 = 3'd4,
    IDX_CTL3 = 3'd5
  } reg_idx_e;

  localparam int unsigned FIRST_CFG = 2;  // first plain storage word
  localparam int unsigned NUM_CFG   = 4;  // baud, ctl1, ctl2, ctl3
  localparam int unsigned PEND_BIT  = 5;  // status: receive pending
  localparam int unsigned RXIE_BIT  = 5;  // ctl1: receive interrupt enable
  localparam logic [REG_W-1:0] STAT_FIXED = 32'h0000_00C0;
endpackage

// File: rtl/uart_rx_slot.sv
module uart_rx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              drain,
  output logic [BYTE_W-1:0] held_byte,
  output logic              pending
);
  // Arrival outranks the drain when both happen in one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_byte <= '0;
      pending   <= 1'b0;
    end else if (load) begin
      held_byte <= load_byte;
      pending   <= 1'b1;
    end else if (drain) begin
      pending   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_cfg_store.sv
module uart_cfg_store #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned NUM_CFG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CFG-1:0]     wr_sel,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       cfg_q [NUM_CFG]
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)         cfg_q[g] <= '0;
      else if (wr_sel[g]) cfg_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic arrival,
  input  logic ie_now,
  input  logic ie_write,
  input  logic ie_wval,
  input  logic pending,
  output logic irq
);
  logic ie_after;
  logic late_enable;
  logic irq_d;

  always_comb begin
    ie_after    = ie_write ? ie_wval : ie_now;
    late_enable = ie_write && ie_wval && !ie_now && pending;
    irq_d       = (arrival && ie_after) || late_enable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic [IDX_W-1:0]  idx;
  logic              rd_en, wr_en;
  logic              data_rd, data_wr, ctl1_wr;
  logic [NUM_CFG-1:0] cfg_wr;
  logic [REG_W-1:0]  cfg_q [NUM_CFG];
  logic [BYTE_W-1:0] held_byte;
  logic              pending;
  logic              ie_now;
  logic [REG_W-1:0]  stat_word;

  assign rx_ready = 1'b1;

  always_comb begin
    idx     = req_addr[ADDR_W-1:2];
    rd_en   = req_valid && !req_write;
    wr_en   = req_valid && req_write;
    data_rd = rd_en && (idx == IDX_DATA);
    data_wr = wr_en && (idx == IDX_DATA);
    ctl1_wr = wr_en && (idx == IDX_CTL1);
    for (int i = 0; i < NUM_CFG; i++)
      cfg_wr[i] = wr_en && (idx == IDX_W'(FIRST_CFG + i));
    ie_now    = cfg_q[IDX_CTL1 - FIRST_CFG][RXIE_BIT];
    stat_word = STAT_FIXED | (REG_W'(pending) << PEND_BIT);
  end

  uart_rx_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rx_valid),
    .load_byte (rx_data),
    .drain     (data_rd),
    .held_byte (held_byte),
    .pending   (pending)
  );

  uart_cfg_store #(.REG_W(REG_W), .NUM_CFG(NUM_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (cfg_wr),
    .wdata  (req_wdata),
    .cfg_q  (cfg_q)
  );

  uart_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arrival  (rx_valid),
    .ie_now   (ie_now),
    .ie_write (ctl1_wr),
    .ie_wval  (req_wdata[RXIE_BIT]),
    .pending  (pending),
    .irq      (irq)
  );

  // Read mux
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (idx == IDX_STAT)       rd_data = stat_word;
      else if (idx == IDX_DATA)  rd_data = REG_W'(held_byte);
      else if (int'(idx) >= FIRST_CFG && int'(idx) < FIRST_CFG + NUM_CFG)
        rd_data = cfg_q[int'(idx) - FIRST_CFG];
    end
  end

  // Transmit strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= data_wr;
      if (data_wr) tx_data <= req_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_rx_regs_chk.sv
module uart_rx_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        data_rd,
  input logic        data_wr,
  input logic        ctl1_wr,
  input logic [31:0] req_wdata,
  input logic        pending,
  input logic        ie_now,
  input logic        irq,
  input logic        tx_valid,
  input logic [7:0]  tx_data
);
  AST_ARRIVAL_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> pending); // R1

  AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_valid) |=> !pending); // R2

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && tx_data == $past(req_wdata[7:0]))); // R3

  AST_TX_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !tx_valid); // R3

  AST_IRQ_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ie_now && !ctl1_wr) |=> irq); // R5

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ie_now && !ctl1_wr) |=> !irq); // R6

  AST_LATE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_wr && req_wdata[5] && !ie_now && pending) |=> irq); // R7

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid || ctl1_wr)); // R5
endmodule

bind uart_rx_regs uart_rx_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .data_rd   (data_rd),
  .data_wr   (data_wr),
  .ctl1_wr   (ctl1_wr),
  .req_wdata (req_wdata),
  .pending   (pending),
  .ie_now    (ie_now),
  .irq       (irq),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data)
);

// File: tb/uart_rx_regs_bench.sv
module uart_rx_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        req_valid, req_write;
  logic [4:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_rx_regs u_uart_rx_regs (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
  endtask

  // One access; drives at negedge, holds across one posedge, returns at next negedge
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #2 d = rd_data;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq", irq, 0);
    chk("R11 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    rd(5'h00, d); chk("R11 status", d, 32'hC0);
    for (int a = 8; a <= 20; a += 4) begin
      rd(5'(a), d); chk("R11 cfg zero", d, 0);
    end
  endtask

  task automatic t_basic_rx();
    logic [31:0] d;
    push(8'h5A);
    chk("R6 no irq", irq, 0);
    rd(5'h00, d); chk("R1 R4 status pending", d, 32'hE0);
    rd(5'h04, d); chk("R2 data", d, 32'h5A);
    rd(5'h00, d); chk("R2 flag cleared", d, 32'hC0);
  endtask

  task automatic t_irq_arrival();
    logic [31:0] d;
    wr(5'h0C, 32'h20);
    push(8'h11);
    chk("R5 irq pulse", irq, 1);
    @(negedge clk); chk("R5 irq one cycle", irq, 0);
    rd(5'h04, d); chk("R5 data", d, 32'h11);
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_late_enable();
    logic [31:0] d;
    wr(5'h0C, 32'h20);  // nothing pending
    chk("R7 no irq when empty", irq, 0);
    wr(5'h0C, 32'h0);
    push(8'h33);
    chk("R6 disabled", irq, 0);
    wr(5'h0C, 32'h20);
    chk("R7 late enable irq", irq, 1);
    @(negedge clk); chk("R7 single pulse", irq, 0);
    wr(5'h0C, 32'h20);  // already set: no new request
    chk("R7 rewrite no irq", irq, 0);
    rd(5'h04, d); chk("R7 data", d, 32'h33);
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    push(8'h77);
    wr(5'h0C, 32'h0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'h04; req_wdata = 32'hFFFF_FFA5;
    @(negedge clk);
    idle_bus();
    chk("R3 tx_valid", tx_valid, 1);
    chk("R3 tx_data", tx_data, 8'hA5);
    chk("R3 no irq", irq, 0);
    @(negedge clk); chk("R3 strobe one cycle", tx_valid, 0);
    rd(5'h00, d); chk("R3 flag kept", d, 32'hE0);
    rd(5'h04, d); chk("R3 slot kept", d, 32'h77);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    push(8'h01);
    push(8'h02);
    rd(5'h04, d); chk("R8 newer byte", d, 32'h02);
    rd(5'h00, d); chk("R8 flag cleared", d, 32'hC0);
  endtask

  task automatic t_collide_read();
    logic [31:0] d;
    push(8'hAA);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'hBB;
    req_valid = 1; req_write = 0; req_addr = 5'h04;
    #2 d = rd_data;
    @(negedge clk);
    rx_valid = 0; idle_bus();
    chk("R9 old byte returned", d, 32'hAA);
    rd(5'h00, d); chk("R9 flag still set", d, 32'hE0);
    rd(5'h04, d); chk("R9 new byte held", d, 32'hBB);
  endtask

  task automatic t_collide_enable();
    logic [31:0] d;
    wr(5'h0C, 32'h0);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'hC3;
    req_valid = 1; req_write = 1; req_addr = 5'h0C; req_wdata = 32'h20;
    @(negedge clk);
    rx_valid = 0; idle_bus();
    chk("R5 R7 combined irq", irq, 1);
    @(negedge clk); chk("R5 R7 no second irq", irq, 0);
    rd(5'h04, d); chk("R5 collide data", d, 32'hC3);
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'h08, 32'h1234_5678);
    wr(5'h10, 32'hDEAD_BEEF);
    wr(5'h15, 32'hCAFE_0001);  // low bits ignored -> 0x14
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h08, d); chk("R10 baud", d, 32'h1234_5678);
    rd(5'h10, d); chk("R10 ctl2", d, 32'hDEAD_BEEF);
    rd(5'h14, d); chk("R10 ctl3", d, 32'hCAFE_0001);
    rd(5'h18, d); chk("R10 unmapped", d, 0);
    rd(5'h1C, d); chk("R10 unmapped hi", d, 0);
    rd(5'h00, d); chk("R4 status write ignored", d, 32'hC0);
    wr(5'h0C, 32'h8000_00DF);
    rd(5'h0C, d); chk("R10 ctl1", d, 32'h8000_00DF);
    wr(5'h0C, 32'h0);
  endtask

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = '0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_rx();
    t_irq_arrival();
    t_late_enable();
    t_tx();
    t_overwrite();
    t_collide_read();
    t_collide_enable();
    t_regs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule